// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. Software loads a 16-bit indirect-address register and a 16-bit write-data register, and then writes a command word. The command word selects the frame kind (Clause 22 or Clause 45), the 2-bit opcode, the 5-bit port address, the 5-bit device or register address, and a start bit. The block serialises one complete frame on the bus. It drives MDIO through an output-enable and releases the line where the PHY must answer. On read frames it captures the 16 data bits the PHY returns.

The start bit doubles as the ready flag. It reads as 1 while a frame is on the wire and returns to 0 by itself once the frame ends. A Clause 45 access takes two commands: an address frame that carries the indirect-address register, then a data frame addressed to the same port and device. The read result and a read-failure flag stay in their own registers until the next read frame completes. MDC is the system clock divided by a build-time half-period count.

Top module: `mdio_master`

## Requirements
- R1: Registers are 32-bit words selected by byte offset. 0x00 is the command, 0x04 the Clause 45 address (bits 15:0), 0x08 the write data (bits 15:0), 0x0C the read data (bits 15:0) and 0x10 the status (bit 0 is the read failure). A misaligned or unmapped offset reads as 0 and is not written. Written address, data and idle command fields (bits 13:0) read back unchanged.
- R2: The command field positions are: bits 4:0 device/register, 9:5 port, 11:10 opcode, 13:12 frame kind, 14 start. Writing the command with bit 14 set while idle launches one frame. Bit 14 then reads 1 for exactly 128·MDC_HALF clock cycles and reads 0 afterwards.
- R3: Each frame begins with 32 ones. The wire start code that follows is 01 when the frame kind is 1 (Clause 22) and 00 for any other kind (0 is Clause 45).
- R4: After the start code, the 2-bit opcode, the 5-bit port and the 5-bit device/register field are sent, each most significant bit first.
- R5: A frame is a write unless it is a read (see R6). A write sends turnaround 10 followed by 16 payload bits, most significant first. The payload is the address register for a Clause 45 opcode 0 and the write-data register otherwise.
- R6: Opcode 2 is a read in Clause 22. Opcodes 2 and 3 are reads in any other kind. On a read the output enable is low for the last 18 bit times, and the 16 bits sampled after the turnaround land in read-data bits 15:0.
- R7: On a read, status bit 0 takes the value sampled in the second turnaround bit time. It is 1 (failed) when the PHY left the line high, and 0 on a good read.
- R8: MDC is low while idle and toggles every MDC_HALF clock cycles during a frame, for 64 rising edges. MDIO and its enable change only on a falling MDC edge, and input is sampled on the rising edge.
- R9: Any command write made while bit 14 reads 1 is ignored. It neither starts a frame nor alters the stored fields.
- R10: The read-data and status registers change only at the end of a read frame. Write and address frames leave them untouched.
- R11: After reset all registers read 0, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable (1 drives the pad) |
| mdioIn | input | 1 | MDIO pad value |

## Verification
The assertions assume that the pad is resolved outside the block and that mdioIn is stable across each rising MDC edge. The bench's PHY responder changes the line only on falling MDC edges, which meets this. They also assume the register strobe is synchronous to clk. The bench drives the strobe on the falling clock edge, so it is never sampled mid-change. Frames are swept over every kind and opcode, every port value and several device, payload and turnaround patterns. Each completed frame is compared bit by bit against a frame model built in the bench.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int TA_IDX     = PRE_BITS + 14;
  localparam int DATA_IDX   = PRE_BITS + 16;

  typedef enum logic [1:0] {
    KIND_C45 = 2'd0,
    KIND_C22 = 2'd1
  } frameKind_e;

  typedef enum logic [2:0] {
    WORD_CMD    = 3'd0,
    WORD_C45ADR = 3'd1,
    WORD_WDATA  = 3'd2,
    WORD_RDATA  = 3'd3,
    WORD_STAT   = 3'd4
  } regWord_e;

  // field order equals the command bit layout 13:0
  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] op;
    logic [4:0] port;
    logic [4:0] dev;
  } cmdFields_t;

  typedef struct packed {
    logic launch;
    logic isRead;
  } dpStrobe_t;

  function automatic logic isReadOp(cmdFields_t c);
    if (c.kind == KIND_C22) return (c.op == 2'd2);
    return c.op[1];
  endfunction

  function automatic logic [1:0] wireStart(cmdFields_t c);
    return (c.kind == KIND_C22) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [FRAME_BITS-1:0] buildFrame(cmdFields_t c, logic [15:0] payload);
    logic [1:0] ta;
    ta = isReadOp(c) ? 2'b11 : 2'b10;
    return {{PRE_BITS{1'b1}}, wireStart(c), c.op, c.port, c.dev, ta, payload};
  endfunction

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic                  frameDone,
  input  logic [15:0]           capData,
  input  logic                  taFail,
  output dpStrobe_t             strobe,
  output logic [FRAME_BITS-1:0] frameWord,
  output logic                  busy,
  output cmdFields_t            cmdOut,
  output logic [15:0]           rdataOut,
  output logic                  errOut
);

  localparam int IDX_W = ADDR_W - 2;

  cmdFields_t cmdQ;
  cmdFields_t newCmd;
  logic       busyQ;
  logic       rdQ;
  logic [15:0] c45AddrQ;
  logic [15:0] wdataQ;
  logic [15:0] rdataQ;
  logic        errQ;
  logic        aligned;
  logic        selCmd, selAdr, selWd, selRd, selSt;
  logic        launch;
  logic [15:0] payload;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign selCmd  = aligned && (regAddr[ADDR_W-1:2] == IDX_W'(WORD_CMD));
  assign selAdr  = aligned && (regAddr[ADDR_W-1:2] == IDX_W'(WORD_C45ADR));
  assign selWd   = aligned && (regAddr[ADDR_W-1:2] == IDX_W'(WORD_WDATA));
  assign selRd   = aligned && (regAddr[ADDR_W-1:2] == IDX_W'(WORD_RDATA));
  assign selSt   = aligned && (regAddr[ADDR_W-1:2] == IDX_W'(WORD_STAT));

  assign newCmd  = cmdFields_t'(regWdata[13:0]);
  assign launch  = regWrEn && selCmd && regWdata[14] && !busyQ;
  assign payload = (newCmd.kind != KIND_C22 && newCmd.op == 2'd0) ? c45AddrQ : wdataQ;

  always_comb begin
    strobe.launch = launch;
    strobe.isRead = isReadOp(newCmd);
    frameWord     = buildFrame(newCmd, payload);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= '0;
      busyQ    <= 1'b0;
      rdQ      <= 1'b0;
      c45AddrQ <= '0;
      wdataQ   <= '0;
      rdataQ   <= '0;
      errQ     <= 1'b0;
    end else begin
      if (regWrEn && selAdr) c45AddrQ <= regWdata[15:0];
      if (regWrEn && selWd)  wdataQ   <= regWdata[15:0];
      if (regWrEn && selCmd && !busyQ) begin
        cmdQ <= newCmd;
        if (regWdata[14]) begin
          busyQ <= 1'b1;
          rdQ   <= isReadOp(newCmd);
        end
      end else if (busyQ && frameDone) begin
        busyQ <= 1'b0;
        if (rdQ) begin
          rdataQ <= capData;
          errQ   <= taFail;
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (selCmd) regRdata = {17'd0, busyQ, cmdQ};
    if (selAdr) regRdata = {16'd0, c45AddrQ};
    if (selWd)  regRdata = {16'd0, wdataQ};
    if (selRd)  regRdata = {16'd0, rdataQ};
    if (selSt)  regRdata = {31'd0, errQ};
  end

  assign busy     = busyQ;
  assign cmdOut   = cmdQ;
  assign rdataOut = rdataQ;
  assign errOut   = errQ;

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [FRAME_BITS-1:0] frameWord,
  input  logic                  mdioIn,
  output logic                  mdc,
  output logic                  mdioOut,
  output logic                  mdioOe,
  output logic                  frameDone,
  output logic [15:0]           capData,
  output logic                  taFail
);

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] TA2_POS  = IDX_W'(TA_IDX + 1);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(DATA_IDX);

  logic                  running;
  logic                  rdQ;
  logic                  mdcQ;
  logic                  tick;
  logic                  riseTick;
  logic                  fallTick;
  logic [IDX_W-1:0]      bitIdx;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [15:0]           capQ;
  logic                  taQ;

  generate
    if (MDC_HALF <= 1) begin : gDivNone
      assign tick = running;
    end else begin : gDivCnt
      localparam int DIV_W = $clog2(MDC_HALF);
      localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(MDC_HALF - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 divCnt <= '0;
        else if (!running || tick) divCnt <= '0;
        else                       divCnt <= divCnt + 1'b1;
      end
      assign tick = running && (divCnt == DIV_MAX);
    end
  endgenerate

  assign riseTick  = tick && !mdcQ;
  assign fallTick  = tick && mdcQ;
  assign frameDone = fallTick && (bitIdx == LAST_POS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      rdQ     <= 1'b0;
      mdcQ    <= 1'b0;
      bitIdx  <= '0;
      shiftQ  <= '0;
      capQ    <= '0;
      taQ     <= 1'b0;
    end else if (!running) begin
      if (strobe.launch) begin
        running <= 1'b1;
        rdQ     <= strobe.isRead;
        mdcQ    <= 1'b0;
        bitIdx  <= '0;
        shiftQ  <= frameWord;
        taQ     <= 1'b0;
      end
    end else if (tick) begin
      mdcQ <= ~mdcQ;
      if (riseTick) begin
        if (rdQ && bitIdx == TA2_POS) taQ <= mdioIn;
        if (bitIdx >= DATA_POS)       capQ <= {capQ[14:0], mdioIn};
      end else if (bitIdx == LAST_POS) begin
        running <= 1'b0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
        shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = running && shiftQ[FRAME_BITS-1];
  assign mdioOe  = running && !(rdQ && bitIdx >= TA_POS);
  assign capData = capQ;
  assign taFail  = taQ;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int MDC_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  dpStrobe_t             strobe;
  logic [FRAME_BITS-1:0] frameWord;
  logic                  frameDone;
  logic [15:0]           capData;
  logic                  taFail;
  logic                  busy;
  cmdFields_t            cmdFields;
  logic [15:0]           rdData;
  logic                  rdErr;

  mdio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .frameDone (frameDone),
    .capData   (capData),
    .taFail    (taFail),
    .strobe    (strobe),
    .frameWord (frameWord),
    .busy      (busy),
    .cmdOut    (cmdFields),
    .rdataOut  (rdData),
    .errOut    (rdErr)
  );

  mdio_datapath #(.MDC_HALF(MDC_HALF)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .frameWord (frameWord),
    .mdioIn    (mdioIn),
    .mdc       (mdc),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .frameDone (frameDone),
    .capData   (capData),
    .taFail    (taFail)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        busy,
  input logic        frameDone,
  input logic [13:0] cmdQ,
  input logic [15:0] rdataQ,
  input logic        errQ
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && !mdc)); // R8

  AST_START_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameDone) |=> busy); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !busy); // R2

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOut)) |-> $fell(mdc)); // R8

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOe)) |-> $fell(mdc)); // R8

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameDone) |=> $stable(cmdQ)); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> ($stable(rdataQ) && $stable(errQ))); // R10

endmodule

bind mdio_master mdio_master_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .mdc       (mdc),
  .mdioOut   (mdioOut),
  .mdioOe    (mdioOe),
  .busy      (busy),
  .frameDone (frameDone),
  .cmdQ      (cmdFields),
  .rdataQ    (rdData),
  .errQ      (rdErr)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;

  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int nRun = 0;
  int nFail = 0;

  // PHY responder state
  int          riseCnt = 0;
  int          base = 0;
  logic        phyRead = 1'b0;
  logic        taBit = 1'b0;
  logic [15:0] resp = '0;
  logic        phyDrive = 1'b0;
  logic        phyBit = 1'b1;
  logic        recPad [64];
  logic        recOe  [64];

  // model of result registers
  logic [15:0] mRdata = '0;
  logic        mErr = 1'b0;

  always #4 clk = ~clk;

  mdio_master #(.ADDR_W(5), .MDC_HALF(H)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign mdioIn = mdioOe ? mdioOut : (phyDrive ? phyBit : 1'b1);

  always @(posedge mdc) begin
    int idx;
    idx = riseCnt - base;
    if (idx >= 0 && idx < 64) begin
      recPad[idx] = mdioIn;
      recOe[idx]  = mdioOe;
    end
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    int idx;
    idx = riseCnt - base;
    phyDrive = phyRead && idx >= 47 && idx < 64;
    if (idx == 47) phyBit = taBit;
    else if (idx >= 48 && idx < 64) phyBit = resp[63-idx];
    else phyBit = 1'b1;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic runOp(input logic [1:0] typ, input logic [1:0] op, input logic [4:0] port,
                       input logic [4:0] dev, input logic [15:0] adrV, input logic [15:0] wdV,
                       input logic [15:0] rspV, input logic taV);
    logic        rd;
    logic [15:0] pay;
    logic [63:0] expF, recF, expOe, recOeV;
    logic [31:0] d;
    int          cyc;
    rd  = (typ == 2'd1) ? (op == 2'd2) : op[1];
    pay = (typ != 2'd1 && op == 2'd0) ? adrV : wdV;
    expF = {32'hFFFF_FFFF, (typ == 2'd1) ? 2'b01 : 2'b00, op, port, dev,
            rd ? {1'b1, taV, rspV} : {2'b10, pay}};
    expOe = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    regWrite(5'h04, {16'hDEAD, adrV});
    regWrite(5'h08, {16'hBEEF, wdV});
    phyRead = rd; taBit = taV; resp = rspV;
    base = riseCnt;
    regWrite(5'h00, {17'd0, 1'b1, typ, op, port, dev});
    cyc = 0;
    forever begin
      regAddr = 5'h00;
      #1;
      if (!regRdata[14]) break;
      cyc++;
      @(negedge clk);
    end
    check(cyc == 128*H, "R2 busy length", 64'(cyc), 64'(128*H));
    repeat (4) @(negedge clk);
    check(riseCnt - base == 64, "R8 rising edges", 64'(riseCnt - base), 64'd64);
    for (int i = 0; i < 64; i++) begin
      recF[63-i]   = recPad[i];
      recOeV[63-i] = recOe[i];
    end
    check(recF[63:30] == expF[63:30], "R3 preamble/start", 64'(recF[63:30]), 64'(expF[63:30]));
    check(recF[29:18] == expF[29:18], "R4 op/port/dev", 64'(recF[29:18]), 64'(expF[29:18]));
    if (rd) begin
      check(recF[17:0] == expF[17:0], "R6 read tail", 64'(recF[17:0]), 64'(expF[17:0]));
      check(recOeV == expOe, "R6 release", recOeV, expOe);
      mRdata = rspV; mErr = taV;
    end else begin
      check(recF[17:0] == expF[17:0], "R5 write tail", 64'(recF[17:0]), 64'(expF[17:0]));
      check(recOeV == expOe, "R5 drive", recOeV, expOe);
    end
    regRead(5'h0C, d);
    check(d == {16'd0, mRdata}, rd ? "R6 rdata" : "R10 rdata kept", 64'(d), 64'(mRdata));
    regRead(5'h10, d);
    check(d == {31'd0, mErr}, rd ? "R7 status" : "R10 status kept", 64'(d), 64'(mErr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 5; a++) begin
      regRead(5'(a*4), d);
      check(d == 0, "R11 reset reg", 64'(d), 64'd0);
    end
    check(!mdc && !mdioOe, "R11 reset pins", {62'd0, mdc, mdioOe}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 readback and decode
    regWrite(5'h04, 32'h0000_1234);
    regRead(5'h04, d); check(d == 32'h1234, "R1 addr readback", 64'(d), 64'h1234);
    regWrite(5'h08, 32'hFFFF_A55A);
    regRead(5'h08, d); check(d == 32'hA55A, "R1 wdata readback", 64'(d), 64'hA55A);
    regWrite(5'h00, 32'h0000_2ABC);
    regRead(5'h00, d); check(d == 32'h2ABC, "R1 idle cmd readback", 64'(d), 64'h2ABC);
    regWrite(5'h05, 32'h0000_7777);
    regRead(5'h04, d); check(d == 32'h1234, "R1 misaligned ignored", 64'(d), 64'h1234);
    regRead(5'h14, d); check(d == 0, "R1 unmapped reads 0", 64'(d), 64'd0);
    check(!mdioOe && !mdc, "R8 idle pins", {62'd0, mdc, mdioOe}, 64'd0);

    // Clause 45 two-frame sequences and Clause 22 basics
    runOp(2'd0, 2'd0, 5'd3, 5'd7, 16'hC0DE, 16'h0000, 16'h0, 1'b0);
    runOp(2'd0, 2'd1, 5'd3, 5'd7, 16'h0000, 16'h5A5A, 16'h0, 1'b0);
    runOp(2'd0, 2'd0, 5'd3, 5'd7, 16'h8001, 16'h0000, 16'h0, 1'b0);
    runOp(2'd0, 2'd3, 5'd3, 5'd7, 16'h8001, 16'h0000, 16'h9C3E, 1'b0);
    runOp(2'd0, 2'd2, 5'd31, 5'd1, 16'h0001, 16'h0000, 16'h1357, 1'b1);
    runOp(2'd1, 2'd1, 5'd0, 5'd31, 16'h0000, 16'hFFFF, 16'h0, 1'b0);
    runOp(2'd1, 2'd2, 5'd16, 5'd2, 16'h0000, 16'h0000, 16'h0001, 1'b0);

    // sweep of every port, all kinds and opcodes
    for (int i = 0; i < 32; i++) begin
      runOp(2'(i % 4), 2'((i / 4) % 4), 5'(i), 5'((i * 7) % 32),
            16'(16'h0F0F ^ (i * 16'h0111)), 16'(16'h3C3C + i * 16'h0203),
            16'(16'hA5C3 ^ (i * 16'h1111)), (i % 5) == 4);
    end

    // R9 command during a frame is ignored
    regWrite(5'h08, 32'h0000_1111);
    phyRead = 1'b0;
    base = riseCnt;
    regWrite(5'h00, {17'd0, 1'b1, 2'd1, 2'd1, 5'd5, 5'd6});
    repeat (10) @(negedge clk);
    regWrite(5'h00, {17'd0, 1'b1, 2'd1, 2'd2, 5'd9, 5'd9});
    regRead(5'h00, d);
    check(d == {17'd0, 1'b1, 2'd1, 2'd1, 5'd5, 5'd6}, "R9 fields kept", 64'(d),
          64'({17'd0, 1'b1, 2'd1, 2'd1, 5'd5, 5'd6}));
    repeat (128 * H + 40) @(negedge clk);
    check(riseCnt - base == 64, "R9 no second frame", 64'(riseCnt - base), 64'd64);
    regRead(5'h00, d);
    check(d[14] == 1'b0, "R9 idle after frame", 64'(d[14]), 64'd0);
    regRead(5'h0C, d);
    check(d == {16'd0, mRdata}, "R10 rdata after write", 64'(d), 64'(mRdata));

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule